// File: doc/BRIEF.md
# Character Display Command Decoder

This block is the command front end of a dot-matrix character display controller. A host strobes 8-bit bytes in together with a register-select bit and a read/write bit. Instruction writes are decoded and update the controller's state: the address counter and the memory it points into, the entry mode, the display, cursor and blink flags, the font and line options, the power options, the horizontal dot scroll, and a display shift offset.

A bank bit, held in the function register, gives two opcode groups a second meaning. With the bank bit set, the display-control opcode writes the font and line options instead of the display flags. In the same bank, the address opcode loads a segment-RAM address and a scroll amount.

Each accepted command starts a busy timer, counted in oscillator clocks. Clear and home are long commands; every other command is short. Instruction writes that arrive while the timer runs are dropped. Data accesses (register-select high) never touch RAM here. They only step the address counter, and optionally the shift offset, in the direction set by the entry mode.

Top module: `chardisp_cmd_decoder`

## Requirements
- R1: After reset every state output is 0, `busy` is 0 and the bank bit (`func[0]`) is 0.
- R2: An accepted instruction is classified by its highest set bit. The byte 0x00 changes no state and does not start the busy timer.
- R3: Clear (0x01) sets `ac` to 0 and `ac_sel` to 0 (display RAM). It holds `busy` for LONG_CYC (410) cycles and leaves `shift_ofs` unchanged.
- R4: Home (0000001x) sets `ac` to 0, `ac_sel` to 0 and `shift_ofs` to 0, and holds `busy` for 410 cycles.
- R5: Entry mode (000001ab) stores `entry` = {a, b}, where a (bit 1) is the step direction (1 = up) and b (bit 0) is the shift enable. It does not move `ac` when it is written.
- R6: Opcode 00001xyz stores `disp` = {x, y, z} (display, cursor, blink) while the bank bit is 0. While the bank bit is 1 it stores `ext_fn` = {x, y, z} (narrow font, inverting cursor, four-line) and leaves `disp` unchanged.
- R7: Function set (001dnrpq) stores `func` = {d, n, r}, where r is the new bank bit. When r = 1 it also stores `pwr[1]` = p (blink enable) and `pwr[0]` = q AND NOT `lp_lock` (low power). When r = 0, `pwr` is unchanged.
- R8: Shift opcode (0001sr..) with s = 0 steps `ac` by one, up if r = 1 and down if r = 0. With s = 1 it steps `shift_ofs` the same way. Both wrap modulo 128, and `ac_sel` is unchanged.
- R9: With the bank bit at 0, 01aaaaaa loads `ac` = aaaaaa with `ac_sel` = 1 (character RAM), and 1aaaaaaa loads `ac` = aaaaaaa with `ac_sel` = 0. With the bank bit at 1, 1hhh?sss loads `hscroll` = hhh, `ac` = sss and `ac_sel` = 2 (segment RAM), and 01xxxxxx changes no state.
- R10: Every accepted command other than clear and home holds `busy` for SHORT_CYC (10) cycles. While `rs` = 0 and `rw` = 1, `dout` = {busy, ac}; otherwise `dout` = 0.
- R11: An instruction write strobed while `busy` is 1 changes no state and does not restart the timer.
- R12: A data access (`stb` with `rs` = 1, read or write) steps `ac` by one in the `entry[1]` direction, modulo 128. When `entry[0]` = 1 it steps `shift_ofs` the same way. It is taken even while busy and never starts the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stb | input | 1 | Access strobe, one cycle per access |
| rs | input | 1 | 0 = instruction register, 1 = data |
| rw | input | 1 | 1 = read, 0 = write |
| din | input | 8 | Instruction byte |
| lp_lock | input | 1 | When high, low power cannot be set |
| dout | output | 8 | Status byte {busy, ac} on instruction read |
| busy | output | 1 | Busy timer running |
| ac | output | 7 | Address counter |
| ac_sel | output | 2 | RAM targeted by ac: 0 display, 1 character, 2 segment |
| shift_ofs | output | 7 | Display shift offset |
| hscroll | output | 3 | Horizontal dot scroll |
| entry | output | 2 | {direction, shift enable} |
| disp | output | 3 | {display, cursor, blink} |
| ext_fn | output | 3 | {narrow font, inverting cursor, four-line} |
| func | output | 3 | {data length, lines, bank bit} |
| pwr | output | 2 | {blink enable, low power} |

## Verification
Every state register drives a port, so a wrong decode or a wrong bank choice appears on the matching output on the clock after the strobe. A stale bank bit shows only when the next display-control or address opcode lands in the wrong register, which can be several commands later. An error in the timer shows at the ports as a busy window of the wrong length. It also shows as a later write being dropped or wrongly taken, so the window length is counted cycle by cycle against the two fixed durations.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

  typedef enum logic [3:0] {
    CMD_NONE  = 4'd0,
    CMD_CLEAR = 4'd1,
    CMD_HOME  = 4'd2,
    CMD_ENTRY = 4'd3,
    CMD_DISP  = 4'd4,
    CMD_SHIFT = 4'd5,
    CMD_FUNC  = 4'd6,
    CMD_CGA   = 4'd7,
    CMD_DDA   = 4'd8
  } cmd_e;

  typedef enum logic [1:0] {
    SEL_DD  = 2'd0,
    SEL_CG  = 2'd1,
    SEL_SEG = 2'd2
  } ram_sel_e;

  // Highest set bit picks the command; the enum order follows bit position.
  function automatic cmd_e classify(input logic [7:0] b);
    cmd_e c;
    c = CMD_NONE;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) c = cmd_e'(4'(i + 1));
    end
    return c;
  endfunction

  function automatic logic is_long(input cmd_e c);
    return (c == CMD_CLEAR) || (c == CMD_HOME);
  endfunction

endpackage

// File: rtl/cdc_cmd_classify.sv
module cdc_cmd_classify
  import chardisp_pkg::*;
(
  input  logic [7:0] din,
  output cmd_e       cmd,
  output logic       cmd_long
);
  always_comb begin
    cmd      = classify(din);
    cmd_long = is_long(cmd);
  end
endmodule

// File: rtl/cdc_busy_timer.sv
module cdc_busy_timer #(
  parameter int SHORT_CYC = 10,
  parameter int LONG_CYC  = 410
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic long_sel,
  output logic busy
);
  localparam int CW = $clog2(LONG_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= long_sel ? CW'(LONG_CYC) : CW'(SHORT_CYC);
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/cdc_mode_regs.sv
module cdc_mode_regs
  import chardisp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  cmd_e       cmd,
  input  logic [4:0] arg,
  input  logic       lp_lock,
  output logic [1:0] entry,
  output logic [2:0] disp,
  output logic [2:0] ext_fn,
  output logic [2:0] func,
  output logic [1:0] pwr
);
  logic bank;
  assign bank = func[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry  <= '0;
      disp   <= '0;
      ext_fn <= '0;
      func   <= '0;
      pwr    <= '0;
    end else if (accept) begin
      case (cmd)
        CMD_ENTRY: entry <= arg[1:0];
        CMD_DISP: begin
          if (bank) ext_fn <= arg[2:0];
          else      disp   <= arg[2:0];
        end
        CMD_FUNC: begin
          func <= arg[4:2];
          if (arg[2]) pwr <= {arg[1], arg[0] & ~lp_lock};
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cdc_addr_unit.sv
module cdc_addr_unit
  import chardisp_pkg::*;
#(
  parameter int AC_W  = 7,
  parameter int OFS_W = 7,
  parameter int CG_W  = 6,
  parameter int SEG_W = 3,
  parameter int HS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  cmd_e             cmd,
  input  logic             bank,
  input  logic [6:0]       arg,
  input  logic             data_step,
  input  logic             dir_up,
  input  logic             shift_en,
  output logic [AC_W-1:0]  ac,
  output logic [1:0]       ac_sel,
  output logic [OFS_W-1:0] shift_ofs,
  output logic [HS_W-1:0]  hscroll
);
  function automatic logic [AC_W-1:0] step_ac(input logic [AC_W-1:0] v, input logic up);
    return up ? v + AC_W'(1) : v - AC_W'(1);
  endfunction

  function automatic logic [OFS_W-1:0] step_ofs(input logic [OFS_W-1:0] v, input logic up);
    return up ? v + OFS_W'(1) : v - OFS_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac        <= '0;
      ac_sel    <= SEL_DD;
      shift_ofs <= '0;
      hscroll   <= '0;
    end else if (accept) begin
      case (cmd)
        CMD_CLEAR: begin
          ac     <= '0;
          ac_sel <= SEL_DD;
        end
        CMD_HOME: begin
          ac        <= '0;
          ac_sel    <= SEL_DD;
          shift_ofs <= '0;
        end
        CMD_SHIFT: begin
          if (arg[3]) shift_ofs <= step_ofs(shift_ofs, arg[2]);
          else        ac        <= step_ac(ac, arg[2]);
        end
        CMD_CGA: begin
          if (!bank) begin
            ac     <= AC_W'(arg[CG_W-1:0]);
            ac_sel <= SEL_CG;
          end
        end
        CMD_DDA: begin
          if (bank) begin
            ac      <= AC_W'(arg[SEG_W-1:0]);
            hscroll <= arg[6:7-HS_W];
            ac_sel  <= SEL_SEG;
          end else begin
            ac     <= AC_W'(arg);
            ac_sel <= SEL_DD;
          end
        end
        default: ;
      endcase
    end else if (data_step) begin
      ac <= step_ac(ac, dir_up);
      if (shift_en) shift_ofs <= step_ofs(shift_ofs, dir_up);
    end
  end
endmodule

// File: rtl/chardisp_cmd_decoder.sv
module chardisp_cmd_decoder
  import chardisp_pkg::*;
#(
  parameter int AC_W      = 7,
  parameter int OFS_W     = 7,
  parameter int HS_W      = 3,
  parameter int SHORT_CYC = 10,
  parameter int LONG_CYC  = 410
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             rs,
  input  logic             rw,
  input  logic [7:0]       din,
  input  logic             lp_lock,
  output logic [AC_W:0]    dout,
  output logic             busy,
  output logic [AC_W-1:0]  ac,
  output logic [1:0]       ac_sel,
  output logic [OFS_W-1:0] shift_ofs,
  output logic [HS_W-1:0]  hscroll,
  output logic [1:0]       entry,
  output logic [2:0]       disp,
  output logic [2:0]       ext_fn,
  output logic [2:0]       func,
  output logic [1:0]       pwr
);
  cmd_e cmd;
  logic cmd_long;
  logic cmd_wr;
  logic cmd_accept;
  logic data_step;

  cdc_cmd_classify u_cls (
    .din      (din),
    .cmd      (cmd),
    .cmd_long (cmd_long)
  );

  assign cmd_wr     = stb & ~rs & ~rw;
  assign cmd_accept = cmd_wr & ~busy & (cmd != CMD_NONE);
  assign data_step  = stb & rs;

  cdc_busy_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cmd_accept),
    .long_sel (cmd_long),
    .busy     (busy)
  );

  cdc_mode_regs u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (cmd_accept),
    .cmd     (cmd),
    .arg     (din[4:0]),
    .lp_lock (lp_lock),
    .entry   (entry),
    .disp    (disp),
    .ext_fn  (ext_fn),
    .func    (func),
    .pwr     (pwr)
  );

  cdc_addr_unit #(.AC_W(AC_W), .OFS_W(OFS_W), .HS_W(HS_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (cmd_accept),
    .cmd       (cmd),
    .bank      (func[0]),
    .arg       (din[6:0]),
    .data_step (data_step),
    .dir_up    (entry[1]),
    .shift_en  (entry[0]),
    .ac        (ac),
    .ac_sel    (ac_sel),
    .shift_ofs (shift_ofs),
    .hscroll   (hscroll)
  );

  assign dout = (~rs & rw) ? {busy, ac} : '0;
endmodule

// File: rtl/cdc_checker.sv
module cdc_checker #(
  parameter int AC_W  = 7,
  parameter int OFS_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stb,
  input logic             rs,
  input logic             rw,
  input logic [7:0]       din,
  input logic             lp_lock,
  input logic             busy,
  input logic [AC_W-1:0]  ac,
  input logic [1:0]       ac_sel,
  input logic [OFS_W-1:0] shift_ofs,
  input logic [1:0]       entry,
  input logic [2:0]       disp,
  input logic [2:0]       ext_fn,
  input logic [2:0]       func,
  input logic [1:0]       pwr,
  input logic             cmd_accept,
  input logic             data_step
);
  AST_NOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !rs && !rw && !busy && din == 8'h00) |=> !busy); // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && din == 8'h01) |=> (ac == '0 && ac_sel == 2'd0 && busy)); // R3
  AST_HOME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && din[7:1] == 7'h01) |=> (ac == '0 && shift_ofs == '0)); // R4
  AST_LP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && din[7:5] == 3'b001 && din[2] && lp_lock) |=> !pwr[0]); // R7
  AST_CG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && !func[0] && din[7:6] == 2'b01)
      |=> (ac == AC_W'($past(din[5:0])) && ac_sel == 2'd1)); // R9
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !rs && !rw && busy) |=> ($stable(entry) && $stable(disp) && $stable(ext_fn)
      && $stable(func) && $stable(pwr) && $stable(ac) && $stable(shift_ofs))); // R11
  AST_DATA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    data_step |=> (ac == ($past(entry[1]) ? $past(ac) + AC_W'(1) : $past(ac) - AC_W'(1)))); // R12
  AST_DATA_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (data_step && !busy) |=> !busy); // R12
endmodule

bind chardisp_cmd_decoder cdc_checker #(.AC_W(AC_W), .OFS_W(OFS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stb        (stb),
  .rs         (rs),
  .rw         (rw),
  .din        (din),
  .lp_lock    (lp_lock),
  .busy       (busy),
  .ac         (ac),
  .ac_sel     (ac_sel),
  .shift_ofs  (shift_ofs),
  .entry      (entry),
  .disp       (disp),
  .ext_fn     (ext_fn),
  .func       (func),
  .pwr        (pwr),
  .cmd_accept (cmd_accept),
  .data_step  (data_step)
);

// File: tb/tb_chardisp_cmd_decoder.sv
`timescale 1ns/1ps
module tb_chardisp_cmd_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0, rs = 1'b0, rw = 1'b0, lp_lock = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic busy;
  logic [6:0] ac, shift_ofs;
  logic [1:0] ac_sel, entry, pwr;
  logic [2:0] hscroll, disp, ext_fn, func;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  int m_ac, m_sel, m_ofs, m_hs, m_entry, m_disp, m_ext, m_func, m_pwr, m_left;

  always #4 clk = ~clk;

  chardisp_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .stb(stb), .rs(rs), .rw(rw), .din(din),
    .lp_lock(lp_lock), .dout(dout), .busy(busy), .ac(ac), .ac_sel(ac_sel),
    .shift_ofs(shift_ofs), .hscroll(hscroll), .entry(entry), .disp(disp),
    .ext_fn(ext_fn), .func(func), .pwr(pwr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ac = 0; m_sel = 0; m_ofs = 0; m_hs = 0; m_entry = 0;
    m_disp = 0; m_ext = 0; m_func = 0; m_pwr = 0; m_left = 0;
  endtask

  function automatic int wrap(input int v);
    return (v + 128) % 128;
  endfunction

  task automatic model_clock();
    bit take;
    int d;
    take = stb && !rs && !rw && (m_left == 0) && (din != 8'h00);
    if (stb && rs) begin
      d = m_entry[1] ? 1 : -1;
      m_ac = wrap(m_ac + d);
      if (m_entry[0]) m_ofs = wrap(m_ofs + d);
    end
    if (take) begin
      m_left = 10;
      casez (din)
        8'b1???????: if (m_func[0]) begin
                       m_ac = din[2:0]; m_hs = din[6:4]; m_sel = 2;
                     end else begin
                       m_ac = din[6:0]; m_sel = 0;
                     end
        8'b01??????: if (!m_func[0]) begin m_ac = din[5:0]; m_sel = 1; end
        8'b001?????: begin
                       m_func = din[4:2];
                       if (din[2]) m_pwr = din[1] * 2 + ((din[0] && !lp_lock) ? 1 : 0);
                     end
        8'b0001????: begin
                       d = din[2] ? 1 : -1;
                       if (din[3]) m_ofs = wrap(m_ofs + d);
                       else        m_ac  = wrap(m_ac + d);
                     end
        8'b00001???: if (m_func[0]) m_ext = din[2:0]; else m_disp = din[2:0];
        8'b000001??: m_entry = din[1:0];
        8'b0000001?: begin m_ac = 0; m_sel = 0; m_ofs = 0; m_left = 410; end
        default:     begin m_ac = 0; m_sel = 0; m_left = 410; end
      endcase
    end else if (m_left > 0) begin
      m_left--;
    end
  endtask

  task automatic compare_all();
    int exp_dout;
    exp_dout = (!rs && rw) ? ((m_left != 0 ? 128 : 0) + m_ac) : 0;
    chk("R10 busy", busy, m_left != 0);
    chk("R10 dout", dout, exp_dout);
    chk("R9 ac", ac, m_ac);
    chk("R9 ac_sel", ac_sel, m_sel);
    chk("R8 shift_ofs", shift_ofs, m_ofs);
    chk("R9 hscroll", hscroll, m_hs);
    chk("R5 entry", entry, m_entry);
    chk("R6 disp", disp, m_disp);
    chk("R6 ext_fn", ext_fn, m_ext);
    chk("R7 func", func, m_func);
    chk("R7 pwr", pwr, m_pwr);
  endtask

  task automatic cyc(input logic s, input logic r, input logic w, input logic [7:0] b);
    stb = s; rs = r; rw = w; din = b;
    @(posedge clk);
    model_clock();
    @(negedge clk);
    stb = 1'b0;
    compare_all();
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      cyc(0, 0, 1, 8'h00);
      n++;
    end
  endtask

  task automatic cmd(input logic [7:0] b, input int dur, input string tag);
    int n;
    cyc(1, 0, 0, b);
    wait_idle(n);
    chk(tag, n, dur);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    compare_all();
    chk("R1 func", func, 0);
    chk("R1 busy", busy, 0);
    // R2: zero byte does nothing
    cyc(1, 0, 0, 8'h00);
    chk("R2 no busy", busy, 0);
    cmd(8'h01, 410, "R3 clear duration");
    cmd(8'h38, 10, "R10 function set duration");
    chk("R7 func", func, 3'b110);
    cmd(8'h0F, 10, "R6 display");
    chk("R6 disp", disp, 3'b111);
    cmd(8'hC5, 10, "R9 ddram");
    chk("R9 ac", ac, 7'h45);
    cmd(8'h06, 10, "R5 entry");
    chk("R5 ac unchanged", ac, 7'h45);
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 8'h00);
    chk("R12 ac up", ac, 7'h48);
    cmd(8'h07, 10, "R5 entry shift");
    cyc(1, 1, 1, 8'h00);
    chk("R12 ofs up", shift_ofs, 1);
    cmd(8'h05, 10, "R5 entry down");
    cmd(8'h80, 10, "R9 ddram 0");
    cyc(1, 1, 0, 8'h00);
    chk("R12 ac wrap", ac, 7'h7F);
    chk("R12 ofs down", shift_ofs, 0);
    cmd(8'h14, 10, "R8 cursor right");
    chk("R8 ac wrap up", ac, 0);
    cmd(8'h10, 10, "R8 cursor left");
    cmd(8'h1C, 10, "R8 display right");
    cmd(8'h1C, 10, "R8 display right");
    chk("R8 ofs", shift_ofs, 2);
    cmd(8'h18, 10, "R8 display left");
    cmd(8'h01, 410, "R3 clear");
    chk("R3 ofs kept", shift_ofs, 1);
    cmd(8'h6A, 10, "R9 cgram");
    chk("R9 cg sel", ac_sel, 1);
    cmd(8'h03, 410, "R4 home");
    chk("R4 ofs", shift_ofs, 0);
    chk("R4 sel", ac_sel, 0);
    // R11: write during busy is dropped; data access still taken (R12)
    cyc(1, 0, 0, 8'h0C);
    cyc(1, 0, 0, 8'h08);
    cyc(1, 0, 1, 8'h00);
    chk("R10 status busy", dout[7], 1);
    cyc(1, 1, 0, 8'h00);
    wait_idle(n);
    chk("R11 busy not restarted", n, 7);
    chk("R11 disp", disp, 3'b100);
    // bank bit
    cmd(8'h3E, 10, "R7 bank on");
    chk("R7 pwr", pwr, 2'b10);
    lp_lock = 1'b1;
    cmd(8'h3D, 10, "R7 locked");
    chk("R7 lp blocked", pwr, 2'b00);
    lp_lock = 1'b0;
    cmd(8'h3F, 10, "R7 unlocked");
    chk("R7 lp set", pwr, 2'b11);
    cmd(8'h0D, 10, "R6 ext");
    chk("R6 ext_fn", ext_fn, 3'b101);
    chk("R6 disp kept", disp, 3'b100);
    cmd(8'hB5, 10, "R9 segram");
    chk("R9 hscroll", hscroll, 3);
    chk("R9 seg sel", ac_sel, 2);
    cmd(8'h55, 10, "R9 bank cg ignored");
    chk("R9 ac kept", ac, 5);
    cmd(8'h30, 10, "R7 bank off");
    chk("R7 pwr kept", pwr, 2'b11);
    cmd(8'h08, 10, "R6 display off");
    cyc(1, 1, 0, 8'h00);
    chk("R10 dout data", dout, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule